// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This controller warns a driver who switches the ignition on but leaves the seat belt unbuckled. It watches a key-on level, a belt-fastened level and a one-cycle seconds tick. When the key turns on, it issues a timer-start pulse and counts ticks. If the belt is still open once the grace period has passed, it raises the alarm enable. The alarm falls when its own duration ends, when the belt is fastened, or when the key is switched off, whichever comes first.

The state machine has three states: idle (key off), waiting (key on, alarm silent) and alarming. A silence flag records that the current key-on session is finished, because the belt was fastened or the alarm already ran its course. Once that flag is set the controller stays quiet until the key goes off. A single saturating seconds counter times both the grace period and the alarm window. The counter clears on the timer-start action. Sound generation and switch debouncing are handled outside this block.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: During and right after reset, `alarm_o` and `timer_start_o` are both 0 and the controller is idle.
- R2: When `key_on_i` is sampled high while idle, `timer_start_o` is high for exactly the one cycle after that edge and stays low for the rest of that key-on session.
- R3: With the key on and the belt open, `alarm_o` rises at the clock edge that samples the 5th `sec_tick_i` pulse after key-on.
- R4: With the key on and the belt open, `alarm_o` falls at the edge that samples the 10th tick after key-on, so the alarm is high for exactly 5 ticks.
- R5: A fastened belt sampled during the alarm drives `alarm_o` low at that same edge.
- R6: A low key sampled during the alarm drives `alarm_o` low at that edge and returns the controller to idle, so a later key-on gives a new start pulse.
- R7: Switching the key off while waiting returns the controller to idle. The next key-on restarts the count, so the alarm again needs a full 5 ticks.
- R8: If the belt is fastened while waiting, no alarm is raised for the rest of that key-on session, even if the belt is opened again and more ticks arrive.
- R9: After the alarm ends by timeout, the controller stays silent while the key stays on, whatever ticks follow. There is no second start pulse.
- R10: If the belt is fastened in the same cycle as the 5th tick, the alarm is not raised.
- R11: While the key is off, ticks and belt changes produce neither an alarm nor a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_on_i | input | 1 | Ignition key level, 1 = on |
| belt_on_i | input | 1 | Seat belt level, 1 = fastened |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| alarm_o | output | 1 | Registered alarm enable |
| timer_start_o | output | 1 | One-cycle pulse when timing starts |

## Verification
Two events can land on the same clock edge. The tick that ends the grace period can coincide with the belt being fastened. The tick that ends the alarm window can coincide with the belt being fastened or the key being turned off. The bench provokes these collisions by driving the belt or key change in the same cycle as the 5th or 10th tick. It judges them on `alarm_o` at that edge: in the grace-period collision the alarm must never rise, and in an end-of-window collision it must fall exactly there. It then confirms the follow-on state through the ports: for a belt collision, ticks that follow stay silent; for a key-off collision, a new key-on produces a start pulse.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ALARM = 2'd2
    } belt_state_e;

    typedef struct packed {
        belt_state_e state;
        logic        silenced;
        logic        alarm;
        logic        start;
    } belt_ctrl_t;

endpackage

// File: rtl/belt_sec_counter.sv
module belt_sec_counter #(
    parameter int CNT_W   = 4,
    parameter int SAT_VAL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] SatLim = CNT_W'(SAT_VAL);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != SatLim)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/belt_fsm.sv
module belt_fsm
    import belt_alarm_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int GRACE_SEC = 5,
    parameter int END_SEC   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_i,
    input  logic             belt_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             clr_o,
    output logic             alarm_o,
    output logic             start_o
);
    localparam logic [CNT_W-1:0] GraceLast = CNT_W'(GRACE_SEC - 1);
    localparam logic [CNT_W-1:0] EndLast   = CNT_W'(END_SEC - 1);

    belt_ctrl_t ctl_d, ctl_q;
    logic       grace_done, window_done;

    // The tick that completes a period is acted on at the edge that samples it.
    assign grace_done  = tick_i && (count_i == GraceLast);
    assign window_done = tick_i && (count_i == EndLast);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.alarm = 1'b0;
        clr_o       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.silenced = 1'b0;
                if (key_i) begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.start = 1'b1;
                    clr_o       = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!key_i) begin
                    ctl_d.state    = ST_IDLE;
                    ctl_d.silenced = 1'b0;
                end else if (belt_i) begin
                    ctl_d.silenced = 1'b1;
                end else if (!ctl_q.silenced && grace_done) begin
                    ctl_d.state = ST_ALARM;
                    ctl_d.alarm = 1'b1;
                end
            end
            ST_ALARM: begin
                if (!key_i) begin
                    ctl_d.state    = ST_IDLE;
                    ctl_d.silenced = 1'b0;
                end else if (belt_i || window_done) begin
                    ctl_d.state    = ST_WAIT;
                    ctl_d.silenced = 1'b1;
                end else begin
                    ctl_d.alarm = 1'b1;
                end
            end
            default: begin
                ctl_d.state    = ST_IDLE;
                ctl_d.silenced = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, silenced: 1'b0, alarm: 1'b0, start: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign alarm_o = ctl_q.alarm;
    assign start_o = ctl_q.start;
endmodule

// File: rtl/belt_alarm_ctrl.sv
module belt_alarm_ctrl #(
    parameter int GRACE_SEC = 5,
    parameter int ALARM_SEC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_on_i,
    input  logic belt_on_i,
    input  logic sec_tick_i,
    output logic alarm_o,
    output logic timer_start_o
);
    localparam int EndSec = GRACE_SEC + ALARM_SEC;
    localparam int CntW   = $clog2(EndSec + 1);

    logic            cnt_clr;
    logic [CntW-1:0] sec_count;

    belt_sec_counter #(
        .CNT_W  (CntW),
        .SAT_VAL(EndSec)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .tick_i (sec_tick_i),
        .count_o(sec_count)
    );

    belt_fsm #(
        .CNT_W    (CntW),
        .GRACE_SEC(GRACE_SEC),
        .END_SEC  (EndSec)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_i  (key_on_i),
        .belt_i (belt_on_i),
        .tick_i (sec_tick_i),
        .count_i(sec_count),
        .clr_o  (cnt_clr),
        .alarm_o(alarm_o),
        .start_o(timer_start_o)
    );
endmodule

// File: rtl/belt_alarm_chk.sv
module belt_alarm_chk (
    input logic clk,
    input logic rst_n,
    input logic key_on_i,
    input logic belt_on_i,
    input logic sec_tick_i,
    input logic alarm_o,
    input logic timer_start_o
);
    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!alarm_o && !timer_start_o);
        end
    end

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start_o |=> !timer_start_o);

    // R3
    alarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> ($past(sec_tick_i) && $past(key_on_i) && !$past(belt_on_i)));

    // R5
    belt_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        belt_on_i |=> !alarm_o);

    // R6
    key_off_mutes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_on_i |=> !alarm_o);

    // R11
    key_off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_on_i |=> !timer_start_o);

    // R9
    no_start_in_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> !timer_start_o);
endmodule

bind belt_alarm_ctrl belt_alarm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_on_i     (key_on_i),
    .belt_on_i    (belt_on_i),
    .sec_tick_i   (sec_tick_i),
    .alarm_o      (alarm_o),
    .timer_start_o(timer_start_o)
);

// File: tb/sim_belt_alarm_ctrl.sv
module sim_belt_alarm_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key = 1'b0;
    logic belt = 1'b0;
    logic tick = 1'b0;
    logic alarm;
    logic tstart;
    int   n_checks = 0;
    int   n_errors = 0;
    int   cycles = 0;

    always #2.5 clk = ~clk;

    belt_alarm_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_on_i     (key),
        .belt_on_i    (belt),
        .sec_tick_i   (tick),
        .alarm_o      (alarm),
        .timer_start_o(tstart)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_errors = n_errors + 1;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive for one cycle and settle just after the edge that samples it.
    task automatic step(input logic k, input logic b, input logic t);
        @(negedge clk);
        key  = k;
        belt = b;
        tick = t;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks_open(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, 1'b1);
            step(1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic go_idle();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        #1;
        check(alarm, 1'b0, "R1 alarm in reset");
        check(tstart, 1'b0, "R1 start in reset");
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        check(alarm, 1'b0, "R1 alarm after reset");
        check(tstart, 1'b0, "R1 start after reset");
    endtask

    task automatic t_full_timeout();
        logic any_alarm = 1'b0;
        logic any_start = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        check(tstart, 1'b1, "R2 start pulse");
        step(1'b1, 1'b0, 1'b0);
        check(tstart, 1'b0, "R2 start one cycle");
        ticks_open(4);
        check(alarm, 1'b0, "R3 silent after 4 ticks");
        step(1'b1, 1'b0, 1'b1);
        check(alarm, 1'b1, "R3 alarm on 5th tick");
        step(1'b1, 1'b0, 1'b0);
        ticks_open(4);
        check(alarm, 1'b1, "R4 alarm held through 9th tick");
        step(1'b1, 1'b0, 1'b1);
        check(alarm, 1'b0, "R4 alarm off on 10th tick");
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b0, 1'b1);
            any_alarm = any_alarm | alarm;
            any_start = any_start | tstart;
        end
        check(any_alarm, 1'b0, "R9 no re-arm after timeout");
        check(any_start, 1'b0, "R9 no second start");
        go_idle();
    endtask

    task automatic t_belt_in_alarm();
        step(1'b1, 1'b0, 1'b0);
        ticks_open(6);
        check(alarm, 1'b1, "R5 alarm active before belt");
        step(1'b1, 1'b1, 1'b0);
        check(alarm, 1'b0, "R5 belt mutes alarm at once");
        step(1'b1, 1'b0, 1'b0);
        ticks_open(6);
        check(alarm, 1'b0, "R5 stays silent after belt");
        go_idle();
    endtask

    task automatic t_key_off_alarm();
        step(1'b1, 1'b0, 1'b0);
        ticks_open(9);
        check(alarm, 1'b1, "R6 alarm active before key off");
        // key off collides with the 10th tick
        step(1'b0, 1'b0, 1'b1);
        check(alarm, 1'b0, "R6 key off mutes alarm");
        step(1'b1, 1'b0, 1'b0);
        check(tstart, 1'b1, "R6 new start after key off");
        go_idle();
    endtask

    task automatic t_key_off_wait();
        step(1'b1, 1'b0, 1'b0);
        ticks_open(3);
        step(1'b0, 1'b0, 1'b0);
        check(alarm, 1'b0, "R7 silent after key off");
        step(1'b1, 1'b0, 1'b0);
        check(tstart, 1'b1, "R7 fresh start pulse");
        ticks_open(4);
        check(alarm, 1'b0, "R7 count restarted");
        step(1'b1, 1'b0, 1'b1);
        check(alarm, 1'b1, "R7 alarm after full grace");
        go_idle();
    endtask

    task automatic t_belt_in_wait();
        logic any_alarm = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        ticks_open(2);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 14; i++) begin
            step(1'b1, 1'b0, 1'b1);
            any_alarm = any_alarm | alarm;
        end
        check(any_alarm, 1'b0, "R8 belt during wait keeps silent");
        go_idle();
    endtask

    task automatic t_grace_collision();
        logic any_alarm = 1'b0;
        step(1'b1, 1'b0, 1'b0);
        ticks_open(4);
        step(1'b1, 1'b1, 1'b1);
        check(alarm, 1'b0, "R10 belt with 5th tick");
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b0, 1'b1);
            any_alarm = any_alarm | alarm;
        end
        check(any_alarm, 1'b0, "R10 no alarm later");
        go_idle();
    endtask

    task automatic t_idle_ticks();
        logic any_out = 1'b0;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, i[0], 1'b1);
            any_out = any_out | alarm | tstart;
        end
        check(any_out, 1'b0, "R11 key off ignores ticks");
    endtask

    initial begin
        t_reset();
        t_full_timeout();
        t_belt_in_alarm();
        t_key_off_alarm();
        t_key_off_wait();
        t_belt_in_wait();
        t_grace_collision();
        t_idle_ticks();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule